// File: doc/BRIEF.md
# Queued ADC Conversion Sequencer

This block steps through a table of conversion command words held in an external synchronous RAM. For each word it runs a timed sampling sequence, hands the selected channel to an external successive-approximation converter through a start/done handshake, and writes the returned result into a result table at the same index. A pass starts on a trigger event. Software chooses the event source: a software strobe, expiry of an internal periodic timer, or a rising edge on an external trigger pin.

A pass stops in one of two ways. At a pause point it waits for the next trigger and then continues from the following word. At the end of the queue it re-arms at entry 0. The end of the queue is found from a sentinel channel code, from the programmed base of a second queue, or from the last table slot. In single-scan mode a pass also needs a software arm bit, and that bit is cleared when the queue ends. In continuous mode the queue stays armed after every pass. Sticky pause and completion flags can each raise an interrupt.

Top module: `adc_qseq`

## Requirements
- R1: trig_mode selects the start event. 0 means none. 1 means a one-cycle pulse on sw_trig. 2 means expiry of the internal timer, which fires every tmr_period cycles while mode 2 is held. 3 means a rising edge of ext_trig, so a held level starts only one pass.
- R2: With cont_scan=0, a trigger is accepted only while single_en is set. single_arm sets single_en, and the end of the queue clears it. With cont_scan=1, every end of queue re-arms at entry 0 for the next trigger.
- R3: Command word layout: bits [5:0] are the channel, bit 6 is pause, bits [8:7] are the sample-time code. Each converted word walks through stage=1 (initial sample, 2 cycles), stage=2 (transfer, 2 cycles), stage=3 (final sample, 2, 4, 8 or 16 cycles for codes 0 to 3) and stage=4 (resolution), in that order. stage is 0 at all other times.
- R4: Resolution begins with a one-cycle conv_start pulse while stage=4, with conv_chan holding the word's channel. stage stays 4 until conv_done.
- R5: A conv_done produces a one-cycle res_we in the next cycle, with res_addr equal to the command word's index and res_data equal to conv_result.
- R6: Words are executed in ascending index order. A new queue starts at entry 0.
- R7: After the result of a word with its pause bit set is written, the block goes idle and sets pause_flag. The next accepted trigger resumes at the following index.
- R8: The queue ends without a conversion when a channel field equals 63. It ends after converting index i when i is 63, or when q2_base is nonzero and i+1 equals q2_base. Each end sets done_flag. End takes precedence over a pause bit on the same word.
- R9: A trigger that arrives while busy is high is ignored.
- R10: pause_flag and done_flag reset to 0 and stay set until flag_clr. irq follows (pause_flag and pause_ie) or (done_flag and done_ie) one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| trig_mode | input | 2 | start event source select |
| cont_scan | input | 1 | 1 continuous, 0 single-scan |
| single_arm | input | 1 | pulse that sets single_en |
| sw_trig | input | 1 | software start strobe |
| ext_trig | input | 1 | external start pin (edge) |
| tmr_period | input | 16 | timer period in cycles (0 stops it) |
| q2_base | input | 6 | first index of queue 2, 0 if unused |
| cmd_addr | output | 6 | command table read address |
| cmd_rdata | input | 9 | command word, one cycle after address |
| res_we | output | 1 | result table write strobe |
| res_addr | output | 6 | result table write address |
| res_data | output | 10 | result value |
| conv_start | output | 1 | converter start pulse |
| conv_chan | output | 6 | channel for the converter |
| conv_done | input | 1 | converter completion pulse |
| conv_result | input | 10 | converter result |
| stage | output | 3 | current conversion stage |
| busy | output | 1 | queue executing |
| single_en | output | 1 | single-scan arm bit |
| pause_flag | output | 1 | sticky pause status |
| done_flag | output | 1 | sticky end-of-queue status |
| flag_clr | input | 1 | clears both flags |
| pause_ie | input | 1 | pause interrupt enable |
| done_ie | input | 1 | completion interrupt enable |
| irq | output | 1 | interrupt request |

## Verification
Tables are tried with a sentinel part way through and with a sentinel at entry 0. These separate conversion-free ending from ending after a conversion. A full 64-entry table with no sentinel isolates the physical-end rule, and a q2_base bound with a pause on the bounding word shows that end wins over pause. Each start source is driven in a way that separates it from its neighbours: a strobe while disabled, a held external level that must start only one pass, a timer whose starts must be exactly one period apart, a second strobe while busy, and single-scan strobes before and after arming. The final-sample length of each result is compared against its word's code, which shows the per-entry sample time is honoured.

// File: rtl/qseq_pkg.sv
package qseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_INIT  = 3'd1,
    ST_XFER  = 3'd2,
    ST_FINAL = 3'd3,
    ST_RES   = 3'd4
  } stage_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DEC, S_SAMP, S_CONV
  } seq_state_e;

  localparam logic [1:0] TM_OFF   = 2'd0;
  localparam logic [1:0] TM_SOFT  = 2'd1;
  localparam logic [1:0] TM_TIMER = 2'd2;
  localparam logic [1:0] TM_EXT   = 2'd3;
endpackage

// File: rtl/qseq_trig.sv
module qseq_trig
  import qseq_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             sw_trig,
  input  logic             ext_trig,
  input  logic [TMR_W-1:0] period,
  output logic             trig
);
  logic             ext_q;
  logic [TMR_W-1:0] tcnt;
  logic             tmr_hit;

  always_comb begin
    tmr_hit = (mode == TM_TIMER) && (period != '0) && (tcnt == period - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= 1'b0;
      tcnt  <= '0;
      trig  <= 1'b0;
    end else begin
      ext_q <= ext_trig;
      if ((mode != TM_TIMER) || tmr_hit) tcnt <= '0;
      else                               tcnt <= tcnt + 1'b1;
      case (mode)
        TM_SOFT:  trig <= sw_trig;
        TM_TIMER: trig <= tmr_hit;
        TM_EXT:   trig <= ext_trig & ~ext_q;
        default:  trig <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/qseq_stage.sv
module qseq_stage
  import qseq_pkg::*;
#(
  parameter int INIT_CYC = 2,
  parameter int XFER_CYC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [1:0] stime,
  output stage_e     phase,
  output logic       fin
);
  localparam int CNT_W = $clog2(16 + INIT_CYC + XFER_CYC);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= ST_OFF;
      cnt   <= '0;
      st_q  <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        phase <= ST_INIT;
        cnt   <= CNT_W'(INIT_CYC - 1);
        st_q  <= stime;
      end else begin
        case (phase)
          ST_INIT: begin
            if (cnt == '0) begin
              phase <= ST_XFER;
              cnt   <= CNT_W'(XFER_CYC - 1);
            end else cnt <= cnt - 1'b1;
          end
          ST_XFER: begin
            if (cnt == '0) begin
              phase <= ST_FINAL;
              cnt   <= (CNT_W'(2) << st_q) - CNT_W'(1);
            end else cnt <= cnt - 1'b1;
          end
          ST_FINAL: begin
            if (cnt == '0) begin
              phase <= ST_OFF;
              fin   <= 1'b1;
            end else cnt <= cnt - 1'b1;
          end
          default: phase <= ST_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/qseq_ctrl.sv
module qseq_ctrl
  import qseq_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int CH_W  = 6,
  parameter int RES_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig,
  input  logic               cont_scan,
  input  logic               single_arm,
  input  logic [IDX_W-1:0]   q2_base,
  input  logic [CH_W+2:0]    cmd_rdata,
  input  logic               stage_fin,
  input  logic               conv_done,
  input  logic [RES_W-1:0]   conv_result,
  input  logic               flag_clr,
  input  logic               pause_ie,
  input  logic               done_ie,
  output logic [IDX_W-1:0]   cmd_addr,
  output logic               res_we,
  output logic [IDX_W-1:0]   res_addr,
  output logic [RES_W-1:0]   res_data,
  output logic               conv_start,
  output logic [CH_W-1:0]    conv_chan,
  output logic               stage_go,
  output logic [1:0]         stage_code,
  output logic               in_conv,
  output logic               busy,
  output logic               pause_flag,
  output logic               done_flag,
  output logic               single_en,
  output logic               irq
);
  localparam logic [IDX_W-1:0] LAST_IDX = '1;
  localparam logic [CH_W-1:0]  END_CH   = '1;

  seq_state_e       state;
  logic [IDX_W-1:0] idx;
  logic             pause_q;

  logic [CH_W-1:0]  w_chan;
  logic             w_pause;
  logic             is_last;
  logic             accept;
  logic             sentinel;
  logic             word_done;
  logic             end_now;
  logic             pause_now;

  always_comb begin
    w_chan     = cmd_rdata[CH_W-1:0];
    w_pause    = cmd_rdata[CH_W];
    stage_code = cmd_rdata[CH_W+2:CH_W+1];
    sentinel   = (state == S_DEC) && (w_chan == END_CH);
    stage_go   = (state == S_DEC) && (w_chan != END_CH);
    is_last    = (idx == LAST_IDX) ||
                 ((q2_base != '0) && ((idx + 1'b1) == q2_base));
    accept     = (state == S_IDLE) && trig && (cont_scan || single_en);
    word_done  = (state == S_CONV) && conv_done;
    end_now    = sentinel || (word_done && is_last);
    pause_now  = word_done && !is_last && pause_q;
    busy       = (state != S_IDLE);
    in_conv    = (state == S_CONV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      idx        <= '0;
      pause_q    <= 1'b0;
      cmd_addr   <= '0;
      res_we     <= 1'b0;
      res_addr   <= '0;
      res_data   <= '0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
      pause_flag <= 1'b0;
      done_flag  <= 1'b0;
      single_en  <= 1'b0;
      irq        <= 1'b0;
    end else begin
      res_we     <= 1'b0;
      conv_start <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            state    <= S_FETCH;
            cmd_addr <= idx;
          end
        end
        S_FETCH: state <= S_DEC;
        S_DEC: begin
          if (sentinel) state <= S_IDLE;
          else begin
            conv_chan <= w_chan;
            pause_q   <= w_pause;
            state     <= S_SAMP;
          end
        end
        S_SAMP: begin
          if (stage_fin) begin
            conv_start <= 1'b1;
            state      <= S_CONV;
          end
        end
        S_CONV: begin
          if (conv_done) begin
            res_we   <= 1'b1;
            res_addr <= idx;
            res_data <= conv_result;
            if (is_last || pause_q) state <= S_IDLE;
            else begin
              state    <= S_FETCH;
              cmd_addr <= idx + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase

      if (end_now)        idx <= '0;
      else if (word_done) idx <= idx + 1'b1;

      done_flag  <= (done_flag & ~flag_clr) | end_now;
      pause_flag <= (pause_flag & ~flag_clr) | pause_now;

      if (single_arm)                 single_en <= 1'b1;
      else if (end_now && !cont_scan) single_en <= 1'b0;

      irq <= (pause_flag & pause_ie) | (done_flag & done_ie);
    end
  end
endmodule

// File: rtl/adc_qseq.sv
module adc_qseq
  import qseq_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int CH_W     = 6,
  parameter int RES_W    = 10,
  parameter int TMR_W    = 16,
  parameter int INIT_CYC = 2,
  parameter int XFER_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       trig_mode,
  input  logic             cont_scan,
  input  logic             single_arm,
  input  logic             sw_trig,
  input  logic             ext_trig,
  input  logic [TMR_W-1:0] tmr_period,
  input  logic [IDX_W-1:0] q2_base,
  output logic [IDX_W-1:0] cmd_addr,
  input  logic [CH_W+2:0]  cmd_rdata,
  output logic             res_we,
  output logic [IDX_W-1:0] res_addr,
  output logic [RES_W-1:0] res_data,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_result,
  output logic [2:0]       stage,
  output logic             busy,
  output logic             single_en,
  output logic             pause_flag,
  output logic             done_flag,
  input  logic             flag_clr,
  input  logic             pause_ie,
  input  logic             done_ie,
  output logic             irq
);
  logic       trig;
  logic       stage_go;
  logic [1:0] stage_code;
  logic       stage_fin;
  logic       in_conv;
  stage_e     phase;

  qseq_trig #(.TMR_W(TMR_W)) u_trig (
    .clk      (clk),
    .rst      (rst),
    .mode     (trig_mode),
    .sw_trig  (sw_trig),
    .ext_trig (ext_trig),
    .period   (tmr_period),
    .trig     (trig)
  );

  qseq_stage #(.INIT_CYC(INIT_CYC), .XFER_CYC(XFER_CYC)) u_stage (
    .clk   (clk),
    .rst   (rst),
    .go    (stage_go),
    .stime (stage_code),
    .phase (phase),
    .fin   (stage_fin)
  );

  qseq_ctrl #(.IDX_W(IDX_W), .CH_W(CH_W), .RES_W(RES_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .trig        (trig),
    .cont_scan   (cont_scan),
    .single_arm  (single_arm),
    .q2_base     (q2_base),
    .cmd_rdata   (cmd_rdata),
    .stage_fin   (stage_fin),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .flag_clr    (flag_clr),
    .pause_ie    (pause_ie),
    .done_ie     (done_ie),
    .cmd_addr    (cmd_addr),
    .res_we      (res_we),
    .res_addr    (res_addr),
    .res_data    (res_data),
    .conv_start  (conv_start),
    .conv_chan   (conv_chan),
    .stage_go    (stage_go),
    .stage_code  (stage_code),
    .in_conv     (in_conv),
    .busy        (busy),
    .pause_flag  (pause_flag),
    .done_flag   (done_flag),
    .single_en   (single_en),
    .irq         (irq)
  );

  always_comb begin
    stage = in_conv ? ST_RES : phase;
  end
endmodule

// File: rtl/qseq_chk.sv
module qseq_chk
  import qseq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] stage,
  input logic       conv_start,
  input logic       conv_done,
  input logic       res_we,
  input logic       busy,
  input logic       single_en,
  input logic       cont_scan,
  input logic       done_flag,
  input logic       pause_flag,
  input logic       flag_clr
);
  // R3
  init_next_chk: assert property (@(posedge clk) disable iff (rst)
    (stage == ST_INIT) |=> (stage == ST_INIT || stage == ST_XFER));
  // R3
  xfer_next_chk: assert property (@(posedge clk) disable iff (rst)
    (stage == ST_XFER) |=> (stage == ST_XFER || stage == ST_FINAL));
  // R3
  final_next_chk: assert property (@(posedge clk) disable iff (rst)
    (stage == ST_FINAL) |=> (stage == ST_FINAL || stage == ST_OFF));
  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  // R4
  start_in_res_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> (stage == ST_RES));
  // R5
  write_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    res_we |-> $past(conv_done));
  // R5
  write_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_we |=> !res_we);
  // R2
  single_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !single_en && !cont_scan) |=> !busy);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> !busy);
  // R10
  pause_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pause_flag && !flag_clr) |=> pause_flag);
endmodule

bind adc_qseq qseq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .stage      (stage),
  .conv_start (conv_start),
  .conv_done  (conv_done),
  .res_we     (res_we),
  .busy       (busy),
  .single_en  (single_en),
  .cont_scan  (cont_scan),
  .done_flag  (done_flag),
  .pause_flag (pause_flag),
  .flag_clr   (flag_clr)
);

// File: tb/sim_adc_qseq.sv
`timescale 1ns/1ps
module sim_adc_qseq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  trig_mode = 2'd0;
  logic        cont_scan = 1'b1;
  logic        single_arm = 1'b0;
  logic        sw_trig = 1'b0;
  logic        ext_trig = 1'b0;
  logic [15:0] tmr_period = 16'd0;
  logic [5:0]  q2_base = 6'd0;
  logic [5:0]  cmd_addr;
  logic [8:0]  cmd_rdata;
  logic        res_we;
  logic [5:0]  res_addr;
  logic [9:0]  res_data;
  logic        conv_start;
  logic [5:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [9:0]  conv_result = 10'd0;
  logic [2:0]  stage;
  logic        busy, single_en, pause_flag, done_flag, irq;
  logic        flag_clr = 1'b0;
  logic        pause_ie = 1'b0;
  logic        done_ie = 1'b1;

  always #10 clk = ~clk;

  adc_qseq u0 (
    .clk(clk), .rst(rst), .trig_mode(trig_mode), .cont_scan(cont_scan),
    .single_arm(single_arm), .sw_trig(sw_trig), .ext_trig(ext_trig),
    .tmr_period(tmr_period), .q2_base(q2_base), .cmd_addr(cmd_addr),
    .cmd_rdata(cmd_rdata), .res_we(res_we), .res_addr(res_addr),
    .res_data(res_data), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result), .stage(stage),
    .busy(busy), .single_en(single_en), .pause_flag(pause_flag),
    .done_flag(done_flag), .flag_clr(flag_clr), .pause_ie(pause_ie),
    .done_ie(done_ie), .irq(irq)
  );

  logic [8:0] mem [64];
  always_ff @(posedge clk) cmd_rdata <= mem[cmd_addr];

  typedef struct packed {
    logic [5:0] a;
    logic [9:0] d;
    logic [4:0] fl;
  } exp_t;
  exp_t sbq[$];

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int n_init = 0, n_xfer = 0, n_fin = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] rfun(input logic [5:0] ch);
    return 10'((int'(ch) * 37 + 5) % 1024);
  endfunction

  function automatic logic [8:0] mkw(input int ch, input bit p, input int code);
    return {2'(code), p, 6'(ch)};
  endfunction

  // converter model: 10 cycles of resolution
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        automatic logic [5:0] ch = conv_chan;
        repeat (9) @(negedge clk);
        conv_result = rfun(ch);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (stage == 3'd1) n_init++;
      if (stage == 3'd2) n_xfer++;
      if (stage == 3'd3) n_fin++;
      if (res_we) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R9", "unexpected result write at addr", int'(res_addr), -1);
        end else begin
          automatic exp_t e = sbq.pop_front();
          chk(res_addr == e.a, "R6", "result index", int'(res_addr), int'(e.a));
          chk(res_data == e.d, "R5", "result data", int'(res_data), int'(e.d));
          chk(n_fin == int'(e.fl), "R3", "final sample cycles", n_fin, int'(e.fl));
          chk(n_init == 2 && n_xfer == 2, "R3", "init+xfer cycles", n_init + n_xfer, 4);
        end
        n_init = 0; n_xfer = 0; n_fin = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic fill(input int sent);
    for (int i = 0; i < 64; i++) mem[i] = mkw((i * 5 + 1) % 63, 1'b0, i % 4);
    if (sent >= 0 && sent < 64) mem[sent] = mkw(63, 1'b0, 0);
  endtask

  task automatic predict(input int start, output int nxt, output bit ended);
    int i = start;
    ended = 1'b0;
    forever begin
      automatic logic [5:0] ch = mem[i][5:0];
      automatic int code = int'(mem[i][8:7]);
      if (ch == 6'd63) begin ended = 1'b1; nxt = 0; return; end
      sbq.push_back('{a: 6'(i), d: rfun(ch), fl: 5'(2 << code)});
      if (i == 63 || (q2_base != 0 && i + 1 == int'(q2_base))) begin
        ended = 1'b1; nxt = 0; return;
      end
      if (mem[i][6]) begin nxt = i + 1; return; end
      i++;
    end
  endtask

  task automatic pulse_sw();
    @(negedge clk) sw_trig = 1'b1;
    @(negedge clk) sw_trig = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clr_flags();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int nx;
    bit en;
    fill(5);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk(!busy, "R6", "busy after reset", busy, 0);
    chk(cmd_addr == 0, "R6", "cmd_addr after reset", cmd_addr, 0);
    chk(stage == 0, "R3", "stage after reset", stage, 0);
    chk(!conv_start && !res_we, "R4", "strobes after reset", conv_start + res_we, 0);
    chk(!pause_flag && !done_flag && !irq, "R10", "flags after reset",
        pause_flag + done_flag + irq, 0);
    chk(!single_en, "R2", "single_en after reset", single_en, 0);

    // software trigger, sentinel at 5
    trig_mode = 2'd1;
    predict(0, nx, en);
    pulse_sw();
    wait_idle();
    chk(done_flag, "R8", "done after sentinel", done_flag, 1);
    chk(!pause_flag, "R8", "no pause at sentinel end", pause_flag, 0);
    chk(irq, "R10", "irq with done_ie", irq, 1);
    chk(sbq.size() == 0, "R6", "pending items", sbq.size(), 0);
    clr_flags();
    chk(!done_flag && !irq, "R10", "flags cleared", done_flag + irq, 0);

    // sentinel at entry 0: no conversion
    fill(0);
    pulse_sw();
    wait_idle();
    chk(done_flag, "R8", "done on leading sentinel", done_flag, 1);
    clr_flags();

    // pause then resume
    fill(7);
    mem[2] = mkw(20, 1'b1, 3);
    predict(0, nx, en);
    pulse_sw();
    wait_idle();
    chk(pause_flag && !done_flag, "R7", "paused status", pause_flag * 2 + done_flag, 2);
    chk(!irq, "R10", "irq masked by pause_ie", irq, 0);
    chk(sbq.size() == 0, "R7", "pending before resume", sbq.size(), 0);
    clr_flags();
    predict(nx, nx, en);
    pulse_sw();
    wait_idle();
    chk(done_flag && !pause_flag, "R7", "resumed to end", done_flag * 2 + pause_flag, 2);
    chk(sbq.size() == 0, "R7", "pending after resume", sbq.size(), 0);
    clr_flags();

    // queue-2 boundary, pause on bounding word ignored
    fill(10);
    q2_base = 6'd4;
    mem[3] = mkw(9, 1'b1, 2);
    predict(0, nx, en);
    pulse_sw();
    wait_idle();
    chk(done_flag && !pause_flag, "R8", "q2 bound ends, end beats pause",
        done_flag * 2 + pause_flag, 2);
    chk(sbq.size() == 0, "R8", "pending at q2 bound", sbq.size(), 0);
    q2_base = 6'd0;
    clr_flags();

    // physical end of table
    fill(-1);
    predict(0, nx, en);
    pulse_sw();
    wait_idle();
    chk(done_flag, "R8", "done at last slot", done_flag, 1);
    chk(sbq.size() == 0, "R8", "pending at last slot", sbq.size(), 0);
    clr_flags();

    // continuous re-arm at entry 0
    mem[3] = mkw(63, 1'b0, 0);
    predict(0, nx, en);
    pulse_sw();
    wait_idle();
    chk(sbq.size() == 0 && done_flag, "R2", "restart at entry 0", sbq.size(), 0);
    clr_flags();

    // trigger while busy ignored
    fill(6);
    predict(0, nx, en);
    pulse_sw();
    repeat (30) @(negedge clk);
    chk(busy, "R9", "busy at second strobe", busy, 1);
    pulse_sw();
    wait_idle();
    repeat (200) @(negedge clk);
    chk(!busy && sbq.size() == 0, "R9", "second strobe ignored", busy, 0);
    clr_flags();

    // mode 0 ignores strobes
    trig_mode = 2'd0;
    pulse_sw();
    repeat (50) @(negedge clk);
    chk(!busy && !done_flag, "R1", "disabled mode ignores strobe", busy + done_flag, 0);

    // single-scan
    trig_mode = 2'd1;
    cont_scan = 1'b0;
    pulse_sw();
    repeat (40) @(negedge clk);
    chk(!busy && !done_flag, "R2", "unarmed single-scan ignores strobe", busy + done_flag, 0);
    @(negedge clk) single_arm = 1'b1;
    @(negedge clk) single_arm = 1'b0;
    chk(single_en, "R2", "single_en set by arm", single_en, 1);
    predict(0, nx, en);
    pulse_sw();
    wait_idle();
    chk(!single_en && done_flag, "R2", "single_en cleared at end", single_en, 0);
    chk(sbq.size() == 0, "R2", "single pass pending", sbq.size(), 0);
    clr_flags();
    pulse_sw();
    repeat (60) @(negedge clk);
    chk(!busy && !done_flag, "R2", "strobe after single pass ignored", busy + done_flag, 0);
    cont_scan = 1'b1;

    // external trigger: held level starts one pass only
    fill(3);
    trig_mode = 2'd3;
    predict(0, nx, en);
    @(negedge clk) ext_trig = 1'b1;
    repeat (300) @(negedge clk);
    ext_trig = 1'b0;
    wait_idle();
    chk(sbq.size() == 0 && done_flag, "R1", "one pass per external edge", sbq.size(), 0);
    clr_flags();
    pulse_sw();
    repeat (50) @(negedge clk);
    chk(!busy && !done_flag, "R1", "strobe ignored in external mode", busy + done_flag, 0);

    // periodic timer
    begin
      int t1, t2;
      fill(2);
      trig_mode = 2'd0;
      tmr_period = 16'd300;
      predict(0, nx, en);
      predict(0, nx, en);
      @(negedge clk) trig_mode = 2'd2;
      while (!busy) @(negedge clk);
      t1 = cyc;
      while (busy) @(negedge clk);
      while (!busy) @(negedge clk);
      t2 = cyc;
      trig_mode = 2'd0;
      wait_idle();
      chk(t2 - t1 == 300, "R1", "timer start spacing", t2 - t1, 300);
      chk(sbq.size() == 0, "R1", "timer passes pending", sbq.size(), 0);
      clr_flags();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule